// File: doc/BRIEF.md
# Hall-Sensor Six-Step Commutation Controller

This block sits between three Hall-sensor comparator levels and the six gate-enable lines of a three-phase MOSFET bridge. The Hall code is synchronised and deglitched, then decoded into one energised high-side leg, one energised low-side leg and one floating leg. A direction input swaps the roles of source and sink for reverse rotation. An active-low brake input, also deglitched, shorts the windings through the three low-side switches. A fault input forces all six gates off.

A separate chopping controller supplies a source-enable level and a synchronous-rectification request. When source-enable is low, the high-side switch of the source leg is removed. If rectification is requested and the overvoltage flag is clear, the low-side switch of that same leg is closed so that the decay current bypasses the body diode. Every change from one switch of a leg to the opposite switch of that leg passes through a programmable dead time in which both gates are off.

Top module: `hall_commutator`

## Requirements
- R1: With dir=1 and the Hall code taken as {C,B,A} bits, the valid codes drive (high leg, low leg): 001→(A,B), 011→(A,C), 010→(B,C), 110→(B,A), 100→(C,A), 101→(C,B). Bit 0 of each gate bus is leg A, bit 1 is leg B and bit 2 is leg C. The third leg floats with both gates off.
- R2: With dir=0, every valid code drives the same two legs with high and low exchanged.
- R3: Hall codes 000 and 111 turn all six gates off on the next clock edge, unless brake or fault applies.
- R4: With the filtered brake input low and no fault, all three low-side gates are on and all high-side gates are off, whatever the Hall code, direction or source-enable.
- R5: fault_in high turns all six gates off on the next clock edge, and they stay off while fault_in is high, brake included.
- R6: The high and low gates of one leg are never on together. A gate turns on only after the opposite gate of its leg has been off for at least DEAD_CYC cycles.
- R7: A change on dir_in or brake_n_in that lasts fewer than CTL_FILT cycles has no effect on the gates.
- R8: A change of the Hall code that lasts fewer than HALL_FILT cycles has no effect on the gates.
- R9: With src_en low, the source leg's high gate is off and the sink leg's low gate stays on. With sync_rect_req high, the source leg's low gate is also turned on, after the dead time.
- R10: With ovp_in high, no rectification low gate is turned on for the source leg.
- R11: During reset all gates are off. The filters take the input value found after reset with no deglitch wait, so the gates drive within 5 cycles of release.
- R12: If a leg's target changes while its dead-time count is still running, the count restarts from DEAD_CYC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hall_in | input | 3 | Hall levels, bit 0 = A, bit 1 = B, bit 2 = C |
| dir_in | input | 1 | Rotation direction, 1 = forward |
| brake_n_in | input | 1 | Brake request, active low |
| fault_in | input | 1 | Combined thermal, undervoltage and lock fault |
| src_en | input | 1 | Chopper source enable, 0 = off interval |
| sync_rect_req | input | 1 | Chopper request for synchronous rectification |
| ovp_in | input | 1 | Supply overvoltage flag |
| gate_hi | output | 3 | High-side gate enables, bit per leg |
| gate_lo | output | 3 | Low-side gate enables, bit per leg |

## Verification
The bench measures the exact cycle at which the source leg's low gate closes after a chop. A design with a short dead-time count would close it a cycle early and risk shoot-through. A design with no restart would close it before the restarted count has expired when an overvoltage blip interrupts the wait. It drives Hall, direction and brake pulses one cycle shorter than their filter windows; a filter that is off by one would let the gates move. It checks that fault beats brake and that brake beats an invalid Hall code, since a wrong priority order would leave a low-side gate on during a fault or leave the bridge floating while braking. It also confirms that the gates drive within a few cycles of reset release, which a filter that starts from zero would miss.

// File: rtl/hall_commutator.sv
module hall_commutator #(
  parameter int DEAD_CYC  = 200,
  parameter int CTL_FILT  = 200,
  parameter int HALL_FILT = 400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] hall_in,
  input  logic       dir_in,
  input  logic       brake_n_in,
  input  logic       fault_in,
  input  logic       src_en,
  input  logic       sync_rect_req,
  input  logic       ovp_in,
  output logic [2:0] gate_hi,
  output logic [2:0] gate_lo
);
  localparam int TW = $clog2(DEAD_CYC + 1);
  localparam int HW = $clog2(HALL_FILT + 1);
  localparam int CW = $clog2(CTL_FILT + 1);

  typedef enum logic [1:0] {L_OFF, L_HI, L_LO} leg_t;

  logic [4:0] s1, s2;
  logic [1:0] boot;
  logic       ready;
  assign ready = (boot == 2'd3);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1   <= '0;
      s2   <= '0;
      boot <= '0;
    end else begin
      s1 <= {brake_n_in, dir_in, hall_in};
      s2 <= s1;
      if (!ready) boot <= boot + 2'd1;
    end

  logic [2:0]    hall_f;
  logic [HW-1:0] hall_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hall_f   <= '0;
      hall_cnt <= '0;
    end else if (boot == 2'd2) begin
      hall_f   <= s2[2:0];
      hall_cnt <= '0;
    end else if (s2[2:0] == hall_f) begin
      hall_cnt <= '0;
    end else if (hall_cnt == HW'(HALL_FILT - 1)) begin
      hall_f   <= s2[2:0];
      hall_cnt <= '0;
    end else begin
      hall_cnt <= hall_cnt + 1'b1;
    end

  logic [1:0] ctl_f;
  for (genvar g = 0; g < 2; g++) begin : g_ctl
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        ctl_f[g] <= 1'b0;
        cnt      <= '0;
      end else if (boot == 2'd2) begin
        ctl_f[g] <= s2[3+g];
        cnt      <= '0;
      end else if (s2[3+g] == ctl_f[g]) begin
        cnt <= '0;
      end else if (cnt == CW'(CTL_FILT - 1)) begin
        ctl_f[g] <= s2[3+g];
        cnt      <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
  end

  logic dir_f, brk_f;
  assign dir_f = ctl_f[0];
  assign brk_f = ctl_f[1];

  logic [2:0] fw_hi, fw_lo, hi_sel, lo_sel;
  always_comb begin
    case (hall_f)
      3'b001:  begin fw_hi = 3'b001; fw_lo = 3'b010; end
      3'b011:  begin fw_hi = 3'b001; fw_lo = 3'b100; end
      3'b010:  begin fw_hi = 3'b010; fw_lo = 3'b100; end
      3'b110:  begin fw_hi = 3'b010; fw_lo = 3'b001; end
      3'b100:  begin fw_hi = 3'b100; fw_lo = 3'b001; end
      3'b101:  begin fw_hi = 3'b100; fw_lo = 3'b010; end
      default: begin fw_hi = 3'b000; fw_lo = 3'b000; end
    endcase
  end
  assign hi_sel = dir_f ? fw_hi : fw_lo;
  assign lo_sel = dir_f ? fw_lo : fw_hi;

  logic rect_ok;
  assign rect_ok = sync_rect_req && !ovp_in;

  leg_t tgt [3];
  always_comb
    for (int i = 0; i < 3; i++) begin
      if (!ready || fault_in)  tgt[i] = L_OFF;
      else if (!brk_f)         tgt[i] = L_LO;
      else if (hi_sel[i])      tgt[i] = src_en ? L_HI : (rect_ok ? L_LO : L_OFF);
      else if (lo_sel[i])      tgt[i] = L_LO;
      else                     tgt[i] = L_OFF;
    end

  for (genvar i = 0; i < 3; i++) begin : g_leg
    leg_t          tgt_q, last, cur;
    logic [TW-1:0] cnt;
    logic          on_hi, on_lo;

    assign cur = on_hi ? L_HI : (on_lo ? L_LO : L_OFF);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        on_hi <= 1'b0;
        on_lo <= 1'b0;
        cnt   <= '0;
        last  <= L_OFF;
        tgt_q <= L_OFF;
      end else begin
        tgt_q <= tgt[i];
        if (cur != L_OFF) begin
          if (tgt[i] != cur) begin
            on_hi <= 1'b0;
            on_lo <= 1'b0;
            cnt   <= TW'(DEAD_CYC);
            last  <= cur;
          end
        end else if (tgt[i] == L_OFF) begin
          if (cnt != '0) cnt <= cnt - 1'b1;
        end else if (tgt[i] == last) begin
          on_hi <= (tgt[i] == L_HI);
          on_lo <= (tgt[i] == L_LO);
        end else if (tgt[i] != tgt_q && cnt != '0) begin
          cnt <= TW'(DEAD_CYC);
        end else if (cnt == '0) begin
          on_hi <= (tgt[i] == L_HI);
          on_lo <= (tgt[i] == L_LO);
        end else begin
          cnt <= cnt - 1'b1;
        end
      end

    assign gate_hi[i] = on_hi;
    assign gate_lo[i] = on_lo;
  end
endmodule

// File: rtl/hall_commutator_chk.sv
module hall_commutator_chk #(
  parameter int DEAD_CYC = 200
) (
  input logic       clk,
  input logic       rst_n,
  input logic       fault_in,
  input logic [2:0] gate_hi,
  input logic [2:0] gate_lo,
  input logic [2:0] hall_f,
  input logic       brk_f,
  input logic       ready
);
  localparam int TW = $clog2(DEAD_CYC + 1);

  a_r6_no_shoot: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_hi & gate_lo) == 3'b000);

  a_r5_fault_off: assert property (@(posedge clk) disable iff (!rst_n)
    fault_in |=> (gate_hi == 3'b000 && gate_lo == 3'b000));

  a_r4_brake_hi_off: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !fault_in && !brk_f) |=> gate_hi == 3'b000);

  a_r3_bad_code_off: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !fault_in && brk_f && (hall_f == 3'b000 || hall_f == 3'b111))
      |=> (gate_hi == 3'b000 && gate_lo == 3'b000));

  a_r11_boot_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> (gate_hi == 3'b000 && gate_lo == 3'b000));

  for (genvar i = 0; i < 3; i++) begin : g_dt
    logic [TW-1:0] hi_gap, lo_gap;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        hi_gap <= TW'(DEAD_CYC);
        lo_gap <= TW'(DEAD_CYC);
      end else begin
        if (gate_hi[i]) hi_gap <= '0;
        else if (hi_gap < TW'(DEAD_CYC)) hi_gap <= hi_gap + 1'b1;
        if (gate_lo[i]) lo_gap <= '0;
        else if (lo_gap < TW'(DEAD_CYC)) lo_gap <= lo_gap + 1'b1;
      end

    a_r6_dead_lo: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_lo[i]) |-> hi_gap >= TW'(DEAD_CYC));

    a_r6_dead_hi: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_hi[i]) |-> lo_gap >= TW'(DEAD_CYC));
  end
endmodule

bind hall_commutator hall_commutator_chk #(.DEAD_CYC(DEAD_CYC)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .fault_in (fault_in),
  .gate_hi  (gate_hi),
  .gate_lo  (gate_lo),
  .hall_f   (hall_f),
  .brk_f    (brk_f),
  .ready    (ready)
);

// File: tb/hall_commutator_tb_top.sv
module hall_commutator_tb_top;
  localparam int DT = 8, CF = 6, HF = 10, SETTLE = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] hall_in = 3'b001;
  logic dir_in = 1'b1, brake_n_in = 1'b1, fault_in = 1'b0;
  logic src_en = 1'b1, sync_rect_req = 1'b0, ovp_in = 1'b0;
  logic [2:0] gate_hi, gate_lo;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hall_commutator #(.DEAD_CYC(DT), .CTL_FILT(CF), .HALL_FILT(HF)) dut_i (
    .clk(clk), .rst_n(rst_n), .hall_in(hall_in), .dir_in(dir_in),
    .brake_n_in(brake_n_in), .fault_in(fault_in), .src_en(src_en),
    .sync_rect_req(sync_rect_req), .ovp_in(ovp_in),
    .gate_hi(gate_hi), .gate_lo(gate_lo));

  function automatic logic [5:0] exp_drive(input logic [2:0] h, input logic d);
    logic [2:0] hi, lo;
    case (h)
      3'b001:  begin hi = 3'b001; lo = 3'b010; end
      3'b011:  begin hi = 3'b001; lo = 3'b100; end
      3'b010:  begin hi = 3'b010; lo = 3'b100; end
      3'b110:  begin hi = 3'b010; lo = 3'b001; end
      3'b100:  begin hi = 3'b100; lo = 3'b001; end
      3'b101:  begin hi = 3'b100; lo = 3'b010; end
      default: begin hi = 3'b000; lo = 3'b000; end
    endcase
    return d ? {hi, lo} : {lo, hi};
  endfunction

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic nxt(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [5:0] gates();
    return {gate_hi, gate_lo};
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    nxt(5);
    chk("R11 gates off in reset", gates(), 6'b0);
    rst_n = 1'b1;
    nxt(5);
    chk("R11 drive soon after release", gates(), exp_drive(3'b001, 1'b1));
  endtask

  task automatic t_forward();
    logic [2:0] seq [6] = '{3'b001, 3'b011, 3'b010, 3'b110, 3'b100, 3'b101};
    dir_in = 1'b1;
    for (int k = 0; k < 6; k++) begin
      hall_in = seq[k];
      nxt(SETTLE);
      chk($sformatf("R1 forward code %b", seq[k]), gates(), exp_drive(seq[k], 1'b1));
    end
  endtask

  task automatic t_reverse();
    logic [2:0] seq [6] = '{3'b001, 3'b101, 3'b100, 3'b110, 3'b010, 3'b011};
    dir_in = 1'b0;
    for (int k = 0; k < 6; k++) begin
      hall_in = seq[k];
      nxt(SETTLE);
      chk($sformatf("R2 reverse code %b", seq[k]), gates(), exp_drive(seq[k], 1'b0));
    end
    dir_in = 1'b1;
    nxt(SETTLE);
  endtask

  task automatic t_invalid();
    hall_in = 3'b000;
    nxt(SETTLE);
    chk("R3 code 000", gates(), 6'b0);
    hall_in = 3'b111;
    nxt(SETTLE);
    chk("R3 code 111", gates(), 6'b0);
  endtask

  task automatic t_brake();
    hall_in = 3'b110;
    src_en = 1'b0;
    brake_n_in = 1'b0;
    nxt(SETTLE);
    chk("R4 brake all low on", gates(), {3'b000, 3'b111});
    hall_in = 3'b111;
    nxt(SETTLE);
    chk("R4 brake beats invalid code", gates(), {3'b000, 3'b111});
    brake_n_in = 1'b1;
    src_en = 1'b1;
    hall_in = 3'b110;
    nxt(SETTLE);
    chk("R4 brake release", gates(), exp_drive(3'b110, 1'b1));
  endtask

  task automatic t_fault();
    hall_in = 3'b001;
    nxt(SETTLE);
    fault_in = 1'b1;
    nxt(1);
    chk("R5 fault off in one cycle", gates(), 6'b0);
    brake_n_in = 1'b0;
    nxt(SETTLE);
    chk("R5 fault beats brake", gates(), 6'b0);
    brake_n_in = 1'b1;
    nxt(SETTLE);
    fault_in = 1'b0;
    nxt(SETTLE);
    chk("R5 fault cleared", gates(), exp_drive(3'b001, 1'b1));
  endtask

  task automatic t_glitch();
    int bad;
    logic [5:0] ref_g;
    ref_g = exp_drive(3'b001, 1'b1);
    bad = 0;
    hall_in = 3'b011;
    nxt(HF - 1);
    hall_in = 3'b001;
    for (int k = 0; k < SETTLE; k++) begin
      nxt(1);
      if (gates() !== ref_g) bad++;
    end
    chk("R8 short hall pulse ignored", {bad != 0, 5'b0}, 6'b0);
    bad = 0;
    dir_in = 1'b0;
    nxt(CF - 1);
    dir_in = 1'b1;
    for (int k = 0; k < SETTLE; k++) begin
      nxt(1);
      if (gates() !== ref_g) bad++;
    end
    chk("R7 short dir pulse ignored", {bad != 0, 5'b0}, 6'b0);
    bad = 0;
    brake_n_in = 1'b0;
    nxt(CF - 1);
    brake_n_in = 1'b1;
    for (int k = 0; k < SETTLE; k++) begin
      nxt(1);
      if (gates() !== ref_g) bad++;
    end
    chk("R7 short brake pulse ignored", {bad != 0, 5'b0}, 6'b0);
  endtask

  task automatic t_sync_rect();
    src_en = 1'b0;
    sync_rect_req = 1'b1;
    nxt(SETTLE);
    chk("R9 rectify source leg", gates(), {3'b000, 3'b011});
    ovp_in = 1'b1;
    nxt(SETTLE);
    chk("R10 overvoltage blocks rectify", gates(), {3'b000, 3'b010});
    ovp_in = 1'b0;
    sync_rect_req = 1'b0;
    nxt(SETTLE);
    chk("R9 off interval without rectify", gates(), {3'b000, 3'b010});
    src_en = 1'b1;
    nxt(SETTLE);
    chk("R9 source restored", gates(), exp_drive(3'b001, 1'b1));
  endtask

  task automatic t_dead_time();
    src_en = 1'b0;
    sync_rect_req = 1'b1;
    nxt(1);
    chk("R6 high off at once", gates(), {3'b000, 3'b010});
    nxt(DT);
    chk("R6 low still off in dead time", gates(), {3'b000, 3'b010});
    nxt(1);
    chk("R6 low on after dead time", gates(), {3'b000, 3'b011});
    src_en = 1'b1;
    sync_rect_req = 1'b0;
    nxt(SETTLE);
  endtask

  task automatic t_restart();
    src_en = 1'b0;
    sync_rect_req = 1'b1;
    nxt(2);
    ovp_in = 1'b1;
    nxt(1);
    ovp_in = 1'b0;
    nxt(9);
    chk("R12 count restarted, low still off", gates(), {3'b000, 3'b010});
    nxt(1);
    chk("R12 low on after restarted count", gates(), {3'b000, 3'b011});
    src_en = 1'b1;
    sync_rect_req = 1'b0;
    nxt(SETTLE);
    chk("R12 back to drive", gates(), exp_drive(3'b001, 1'b1));
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    nxt(1);
    t_reset();
    t_forward();
    t_reverse();
    t_invalid();
    t_brake();
    t_fault();
    t_glitch();
    t_sync_rect();
    t_dead_time();
    t_restart();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end
endmodule